// File: doc/BRIEF.md
# Two-channel DMA controller

This block moves blocks of data for a host processor without the processor touching each word. Two independent channels each hold a source address, a destination address, a transfer count and a configuration. When a channel is armed, it competes for a single master port. Each transfer reads one item from the source and then writes that same item to the destination. The item is a byte, a half-word or a word. Either address side can be held fixed, which suits a peripheral data register. The block therefore covers memory-to-memory, I/O-to-memory and I/O-to-I/O moves.

Before it uses the master port, the block asks a system arbiter for the bus with a request/grant pair. Each channel picks how it holds the bus. In cycle-steal mode the request is released after every transfer. In burst mode the request is held until the whole block has moved. A global mode bit selects how the two channels share the engine: fixed priority, where channel 0 wins, or round-robin, where the channel served last yields. Each channel has its own interrupt line. The line reports completion or a fault, and each of the two causes can be masked.

Top module: `dma2_ctrl`

## Requirements
- R1: After reset, bus_req_o, m_rd_o, m_wr_o and both irq_o bits are 0, and every status and control register reads 0.
- R2: Each transfer is one read strobe at the source address followed by one write strobe at the destination address. The write carries the data returned by the read. Read and write strobes are never high together.
- R3: The configuration field cfg[1:0] selects the size: 0 is byte, 1 is half-word, 2 is word. m_size_o carries this field. After each write, each address steps by 1, 2 or 4, except on a side held fixed by cfg[2] (source) or cfg[3] (destination).
- R4: The count register is 16 bits, and a value of 0 means 65,536 transfers. The register reads back the transfers still to go, so it reads 0 after completion. When the last write completes, status bit 0 (done) is set and the channel stops.
- R5: With mode bit 0 of register 0x7 cleared (fixed), channel 0 is served first whenever both channels are requesting.
- R6: With mode bit 0 of register 0x7 set (round-robin), a channel just served loses to the other one if both are requesting.
- R7: With cfg[4]=0 (cycle-steal), bus_req_o falls after every completed write, so each transfer raises it again.
- R8: With cfg[4]=1 (burst), bus_req_o rises once for the block and stays high until the last write.
- R9: Writing 1 to control bit 0 (register index 4) arms a channel. With cfg[5]=1, the channel transfers only while its dreq_i bit is high. While dreq_i is low, no transfer takes place.
- R10: A fault stops the channel and sets status bit 1 (error). There are two kinds of fault. The first is arming with a source or destination address misaligned to the size, or with size code 3; this causes no bus activity. The second is an m_err_i response with m_ready_i.
- R11: irq_o[c] is high when done is set and cfg[6]=1, or when error is set and cfg[7]=1. Writing 1 to a status bit clears it.
- R12: m_rd_o and m_wr_o are only driven while bus_gnt_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: bit 3 is the channel, bits 2:0 the index (0 src, 1 dst, 2 count, 3 cfg, 4 ctrl, 5 status; 0x7 mode) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| dreq_i | input | 2 | External transfer request, one bit per channel |
| bus_req_o | output | 1 | Bus request to the system arbiter |
| bus_gnt_i | input | 1 | Bus grant from the system arbiter |
| m_addr_o | output | 32 | Master address |
| m_size_o | output | 2 | Master access size (0 byte, 1 half, 2 word) |
| m_rd_o | output | 1 | Master read strobe |
| m_wr_o | output | 1 | Master write strobe |
| m_wdata_o | output | 32 | Master write data |
| m_rdata_i | input | 32 | Master read data |
| m_ready_i | input | 1 | Access complete |
| m_err_i | input | 1 | Error response, valid with m_ready_i |
| irq_o | output | 2 | Interrupt, one per channel |

## Verification
The assertions assume that the system arbiter keeps bus_gnt_i high for as long as bus_req_o stays high once it has granted. They also assume that m_err_i is only meaningful alongside m_ready_i. The bench derives the grant from the request through one register, so a grant never drops while the engine holds the bus. The bench raises the error response only during the one test that injects a read fault. Registers are reprogrammed only while the channel involved is idle. The bench arms channels that share the engine while their request lines are low, and then raises the request lines together.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int NCH = 2;

  localparam logic [2:0] IDX_SRC  = 3'd0;
  localparam logic [2:0] IDX_DST  = 3'd1;
  localparam logic [2:0] IDX_CNT  = 3'd2;
  localparam logic [2:0] IDX_CFG  = 3'd3;
  localparam logic [2:0] IDX_CTRL = 3'd4;
  localparam logic [2:0] IDX_STAT = 3'd5;
  localparam logic [2:0] IDX_MODE = 3'd7;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} xfer_size_e;

  typedef struct packed {
    logic       err_ie;
    logic       done_ie;
    logic       ext_en;
    logic       burst;
    logic       dst_fix;
    logic       src_fix;
    xfer_size_e size;
  } chan_cfg_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_ACQ, ENG_RD, ENG_WR} eng_state_e;

  function automatic logic [2:0] size_bytes(xfer_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic bad_align(logic [1:0] a, xfer_size_e s);
    case (s)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return a[0];
      SZ_WORD: return |a;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dma2_channel.sv
module dma2_channel
  import dma2_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [2:0]  idx_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        dreq_i,
  output logic        req_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output chan_cfg_t   cfg_o,
  output logic        last_o,
  input  logic        step_i,
  input  logic        fault_i,
  output logic        irq_o
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] rem_q;
  chan_cfg_t     cfg_q;
  logic          active_q, done_q, err_q;
  logic          arm, misal;
  logic [AW-1:0] step_sz;

  assign step_sz = AW'(size_bytes(cfg_q.size));
  assign arm     = wr_i && idx_i == IDX_CTRL && wdata_i[0] && !active_q;
  assign misal   = bad_align(src_q[1:0], cfg_q.size) || bad_align(dst_q[1:0], cfg_q.size);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      dst_q    <= '0;
      rem_q    <= '0;
      cfg_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (wr_i && !active_q) begin
        case (idx_i)
          IDX_SRC: src_q <= wdata_i[AW-1:0];
          IDX_DST: dst_q <= wdata_i[AW-1:0];
          IDX_CNT: rem_q <= wdata_i[CW-1:0];
          IDX_CFG: cfg_q <= chan_cfg_t'(wdata_i[7:0]);
          default: ;
        endcase
      end
      if (wr_i && idx_i == IDX_STAT) begin
        done_q <= done_q & ~wdata_i[0];
        err_q  <= err_q & ~wdata_i[1];
      end
      if (arm) begin
        if (misal) err_q <= 1'b1;
        else begin
          active_q <= 1'b1;
          done_q   <= 1'b0;
        end
      end
      if (step_i) begin
        rem_q <= rem_q - 1'b1;
        if (!cfg_q.src_fix) src_q <= src_q + step_sz;
        if (!cfg_q.dst_fix) dst_q <= dst_q + step_sz;
        if (last_o) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
      if (fault_i) begin
        active_q <= 1'b0;
        err_q    <= 1'b1;
      end
    end
  end

  assign req_o  = active_q && (!cfg_q.ext_en || dreq_i);
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cfg_o  = cfg_q;
  assign last_o = rem_q == CW'(1);
  assign irq_o  = (done_q && cfg_q.done_ie) || (err_q && cfg_q.err_ie);

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      IDX_SRC:  rdata_o = 32'(src_q);
      IDX_DST:  rdata_o = 32'(dst_q);
      IDX_CNT:  rdata_o = 32'(rem_q);
      IDX_CFG:  rdata_o = {24'd0, cfg_q};
      IDX_CTRL: rdata_o = {31'd0, active_q};
      IDX_STAT: rdata_o = {30'd0, err_q, done_q};
      default:  rdata_o = '0;
    endcase
  end

  AST_FAULT_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (!active_q && err_q)); // R10
  AST_LAST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !fault_i) |=> (done_q && !active_q && rem_q == '0)); // R4
  AST_SRC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !cfg_q.src_fix && !wr_i) |=> src_q == $past(src_q) + AW'(size_bytes($past(cfg_q.size)))); // R3
  AST_DST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cfg_q.dst_fix) |=> $stable(dst_q)); // R3
  AST_MISAL_NOARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && misal) |=> (!active_q && err_q)); // R10
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
  import dma2_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic           rr_mode_i,
  input  logic           take_i,
  output logic           valid_o,
  output logic           ch_o
);
  logic last_q;

  always_comb begin
    if (&req_i) ch_o = rr_mode_i ? ~last_q : 1'b0;
    else        ch_o = req_i[1];
  end
  assign valid_o = |req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= 1'b1;
    else if (take_i) last_q <= ch_o;
  end

  AST_FIXED_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !rr_mode_i && &req_i) |-> !ch_o); // R5
  AST_RR_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && rr_mode_i && &req_i) |=> last_q != $past(last_q)); // R6
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arb_valid_i,
  input  logic          arb_ch_i,
  output logic          take_o,
  output logic          sel_o,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  xfer_size_e    size_i,
  input  logic          burst_i,
  input  logic          last_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [AW-1:0] m_addr_o,
  output logic [1:0]    m_size_o,
  output logic          m_rd_o,
  output logic          m_wr_o,
  output logic [DW-1:0] m_wdata_o,
  input  logic [DW-1:0] m_rdata_i,
  input  logic          m_ready_i,
  input  logic          m_err_i,
  output logic          step_o,
  output logic          fault_o
);
  eng_state_e    state_q, state_d;
  logic          sel_q;
  logic [DW-1:0] buf_q;
  logic          rd_done, wr_done;

  assign take_o  = state_q == ENG_IDLE && arb_valid_i;
  assign rd_done = state_q == ENG_RD && m_ready_i;
  assign wr_done = state_q == ENG_WR && m_ready_i;
  assign step_o  = wr_done && !m_err_i;
  assign fault_o = (rd_done || wr_done) && m_err_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ENG_IDLE: if (arb_valid_i) state_d = ENG_ACQ;
      ENG_ACQ:  if (bus_gnt_i) state_d = ENG_RD;
      ENG_RD:   if (m_ready_i) state_d = m_err_i ? ENG_IDLE : ENG_WR;
      ENG_WR:   if (m_ready_i) state_d = (!m_err_i && burst_i && !last_i) ? ENG_RD : ENG_IDLE;
      default:  state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      sel_q   <= 1'b0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take_o) sel_q <= arb_ch_i;
      if (rd_done && !m_err_i) buf_q <= m_rdata_i;
    end
  end

  assign sel_o     = sel_q;
  assign bus_req_o = state_q != ENG_IDLE;
  assign m_rd_o    = state_q == ENG_RD;
  assign m_wr_o    = state_q == ENG_WR;
  assign m_addr_o  = (state_q == ENG_WR) ? dst_i : src_i;
  assign m_size_o  = size_i;
  assign m_wdata_o = buf_q;

  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_rd_o && m_wr_o)); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_wr_o) |-> $past(m_rd_o)); // R2
  AST_NEED_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rd_o || m_wr_o) |-> bus_gnt_i); // R12
  AST_STEAL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_wr_o && m_ready_i && !burst_i) |=> !bus_req_o); // R7
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_wr_o && m_ready_i && !m_err_i && burst_i && !last_i) |=> (bus_req_o && m_rd_o)); // R8
endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
  import dma2_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic [1:0]    dreq_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [AW-1:0] m_addr_o,
  output logic [1:0]    m_size_o,
  output logic          m_rd_o,
  output logic          m_wr_o,
  output logic [DW-1:0] m_wdata_o,
  input  logic [DW-1:0] m_rdata_i,
  input  logic          m_ready_i,
  input  logic          m_err_i,
  output logic [1:0]    irq_o
);
  logic            rr_mode_q;
  logic [NCH-1:0]  ch_req, ch_last;
  logic [AW-1:0]   ch_src [NCH];
  logic [AW-1:0]   ch_dst [NCH];
  chan_cfg_t       ch_cfg [NCH];
  logic [31:0]     ch_rdata [NCH];
  logic            arb_valid, arb_ch, take, sel, step, fault;
  logic            mode_sel;

  assign mode_sel = reg_addr_i == {1'b0, IDX_MODE};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rr_mode_q <= 1'b0;
    else if (reg_we_i && mode_sel) rr_mode_q <= reg_wdata_i[0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2_channel #(.AW(AW), .CW(CW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_we_i && reg_addr_i[3] == 1'(c) && !mode_sel),
      .idx_i   (reg_addr_i[2:0]),
      .wdata_i (reg_wdata_i),
      .rdata_o (ch_rdata[c]),
      .dreq_i  (dreq_i[c]),
      .req_o   (ch_req[c]),
      .src_o   (ch_src[c]),
      .dst_o   (ch_dst[c]),
      .cfg_o   (ch_cfg[c]),
      .last_o  (ch_last[c]),
      .step_i  (step && sel == 1'(c)),
      .fault_i (fault && sel == 1'(c)),
      .irq_o   (irq_o[c])
    );
  end

  assign reg_rdata_o = mode_sel ? {31'd0, rr_mode_q} : ch_rdata[reg_addr_i[3]];

  dma2_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (ch_req),
    .rr_mode_i (rr_mode_q),
    .take_i    (take),
    .valid_o   (arb_valid),
    .ch_o      (arb_ch)
  );

  dma2_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arb_valid_i (arb_valid),
    .arb_ch_i    (arb_ch),
    .take_o      (take),
    .sel_o       (sel),
    .src_i       (ch_src[sel]),
    .dst_i       (ch_dst[sel]),
    .size_i      (ch_cfg[sel].size),
    .burst_i     (ch_cfg[sel].burst),
    .last_i      (ch_last[sel]),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .m_addr_o    (m_addr_o),
    .m_size_o    (m_size_o),
    .m_rd_o      (m_rd_o),
    .m_wr_o      (m_wr_o),
    .m_wdata_o   (m_wdata_o),
    .m_rdata_i   (m_rdata_i),
    .m_ready_i   (m_ready_i),
    .m_err_i     (m_err_i),
    .step_o      (step),
    .fault_o     (fault)
  );

  AST_IRQ_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> irq_o == 2'b00); // R1
endmodule

// File: tb/dma2_ctrl_tb_top.sv
module dma2_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;
  localparam int NVEC = 6;
  // {ch, size[1:0], src_fix, dst_fix, burst, cnt[15:0], src[15:0], dst[15:0]}
  localparam logic [53:0] VEC [NVEC] = '{
    {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 16'd5, 16'h0100, 16'h1000},
    {1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 16'd3, 16'h0202, 16'h2000},
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 16'd7, 16'h0301, 16'h1003},
    {1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 16'd4, 16'h0400, 16'h2100},
    {1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 16'd2, 16'h0500, 16'h1200},
    {1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 16'd1, 16'h0601, 16'h2301}
  };

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [1:0] dreq = 0;
  logic bus_req, bus_gnt = 0;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0] m_size;
  logic m_rd, m_wr, m_err;
  logic err_en = 0;
  logic [1:0] irq;
  int checks = 0, fails = 0;
  int wtot = 0, rtot = 0, rises = 0;
  logic [31:0] last_waddr = 0, last_wdata = 0;
  logic [1:0] last_wsize = 0;
  logic [3:0] ord = 0;
  logic req_d = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_fn(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  assign m_rdata = mem_fn(m_addr);
  assign m_err   = err_en && m_rd;

  dma2_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dreq_i(dreq),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .m_addr_o(m_addr), .m_size_o(m_size),
    .m_rd_o(m_rd), .m_wr_o(m_wr), .m_wdata_o(m_wdata), .m_rdata_i(m_rdata),
    .m_ready_i(1'b1), .m_err_i(m_err), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    bus_gnt <= bus_req;
    req_d   <= bus_req;
    if (bus_req && !req_d) rises <= rises + 1;
    if (m_rd && !m_err) rtot <= rtot + 1;
    if (m_wr) begin
      wtot       <= wtot + 1;
      last_waddr <= m_addr;
      last_wdata <= m_wdata;
      last_wsize <= m_size;
      ord        <= {ord[2:0], m_addr[13]};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input int ch, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq[ch]) break;
    end
  endtask

  task automatic setup(input logic ch, input logic [31:0] src, input logic [31:0] dst,
                       input logic [15:0] cnt, input logic [7:0] cfg);
    wr({ch, 3'd0}, src);
    wr({ch, 3'd1}, dst);
    wr({ch, 3'd2}, {16'd0, cnt});
    wr({ch, 3'd3}, {24'd0, cfg});
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w0, r0, q0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_req == 0 && m_rd == 0 && m_wr == 0, "R1 bus idle", {bus_req, m_rd, m_wr}, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rst_n = 1;
    rd(4'h5, d); chk(d == 0, "R1 status0", d, 0);
    rd(4'hD, d); chk(d == 0, "R1 status1", d, 0);
    rd(4'h4, d); chk(d == 0, "R1 ctrl0", d, 0);

    // Vector table: R2 R3 R4 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic ch; logic [1:0] sz; logic sf, df, bu; logic [15:0] cnt;
      logic [31:0] src, dst, ls, ld;
      {ch, sz, sf, df, bu, cnt, src[15:0], dst[15:0]} = VEC[v];
      src[31:16] = 0; dst[31:16] = 0;
      w0 = wtot; r0 = rtot; q0 = rises;
      setup(ch, src, dst, cnt, {1'b1, 1'b1, 1'b0, bu, df, sf, sz});
      wr({ch, 3'd4}, 1);
      wait_irq(ch, 500);
      @(negedge clk);
      ls = src + (sf ? 0 : ((32'(cnt) - 1) << sz));
      ld = dst + (df ? 0 : ((32'(cnt) - 1) << sz));
      chk(irq[ch] == 1, "R4 done irq", irq, {ch, ~ch});
      chk(wtot - w0 == int'(cnt), "R4 write count", wtot - w0, cnt);
      chk(rtot - r0 == int'(cnt), "R2 read count", rtot - r0, cnt);
      chk(last_waddr == ld, "R3 last dst addr", last_waddr, ld);
      chk(last_wdata == mem_fn(ls), "R2 data moved", last_wdata, mem_fn(ls));
      chk(last_wsize == sz, "R3 size", last_wsize, sz);
      chk(rises - q0 == (bu ? 1 : int'(cnt)), bu ? "R8 single request" : "R7 request per transfer",
          rises - q0, bu ? 1 : cnt);
      rd({ch, 3'd2}, d); chk(d == 0, "R4 remaining", d, 0);
      rd({ch, 3'd5}, d); chk(d == 1, "R4 status done", d, 1);
      wr({ch, 3'd5}, 1);
      @(negedge clk);
      chk(irq[ch] == 0, "R11 w1c clears irq", irq, 0);
    end

    // R10 misaligned arm
    w0 = wtot; q0 = rises;
    setup(1'b1, 32'h402, 32'h2000, 16'd2, 8'h82);
    wr(4'hC, 1);
    repeat (10) @(negedge clk);
    chk(wtot == w0 && rises == q0, "R10 misaligned no bus", wtot - w0, 0);
    rd(4'hD, d); chk(d == 2, "R10 misaligned status", d, 2);
    chk(irq[1] == 1, "R11 error irq", irq, 2'b10);
    wr(4'hD, 2);
    setup(1'b1, 32'h400, 32'h2000, 16'd2, 8'h83);
    wr(4'hC, 1);
    repeat (5) @(negedge clk);
    rd(4'hD, d); chk(d == 2 && wtot == w0, "R10 reserved size", d, 2);
    wr(4'hD, 2);

    // R10 bus error on read
    w0 = wtot;
    setup(1'b1, 32'h400, 32'h2000, 16'd3, 8'h82);
    err_en = 1;
    wr(4'hC, 1);
    wait_irq(1, 50);
    err_en = 0;
    rd(4'hD, d); chk(d == 2, "R10 bus error status", d, 2);
    rd(4'hC, d); chk(d == 0, "R10 channel stopped", d, 0);
    chk(wtot == w0, "R10 no write after error", wtot - w0, 0);
    wr(4'hD, 2);

    // R11 masked completion
    setup(1'b0, 32'h100, 32'h1000, 16'd1, 8'h02);
    wr(4'h4, 1);
    repeat (20) @(negedge clk);
    chk(irq[0] == 0, "R11 masked irq", irq, 0);
    rd(4'h5, d); chk(d == 1, "R11 masked status", d, 1);
    wr(4'h5, 1);
    rd(4'h5, d); chk(d == 0, "R11 w1c", d, 0);

    // R9 external request gating
    w0 = wtot;
    setup(1'b0, 32'h100, 32'h1000, 16'd2, 8'h62);
    wr(4'h4, 1);
    repeat (20) @(negedge clk);
    chk(wtot == w0, "R9 held without dreq", wtot - w0, 0);
    dreq[0] = 1;
    wait_irq(0, 100);
    dreq = 0;
    chk(wtot - w0 == 2, "R9 runs on dreq", wtot - w0, 2);
    wr(4'h5, 3);

    // R5 fixed priority, then R6 round-robin
    for (int m = 0; m < 2; m++) begin
      wr(4'h7, m);
      setup(1'b0, 32'h100, 32'h1000, 16'd2, 8'h62);
      setup(1'b1, 32'h200, 32'h2000, 16'd2, 8'h62);
      wr(4'h4, 1);
      wr(4'hC, 1);
      @(negedge clk);
      dreq = 2'b11;
      wait_irq(0, 100);
      wait_irq(1, 100);
      dreq = 0;
      if (m == 0) chk(ord == 4'b0011, "R5 fixed order", ord, 4'b0011);
      else        chk(ord == 4'b0101, "R6 rotate order", ord, 4'b0101);
      wr(4'h5, 3);
      wr(4'hD, 3);
    end
    wr(4'h7, 0);

    // R4 count 0 means 65536, R8 burst held
    w0 = wtot; q0 = rises;
    setup(1'b0, 32'h0, 32'h100000, 16'd0, 8'h52);
    wr(4'h4, 1);
    wait_irq(0, 140000);
    @(negedge clk);
    chk(wtot - w0 == 65536, "R4 zero count", wtot - w0, 65536);
    chk(rises - q0 == 1, "R8 burst one request", rises - q0, 1);
    chk(last_waddr == 32'h100000 + 32'h3FFFC, "R3 word step", last_waddr, 32'h13FFFC);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule